// File: doc/BRIEF.md
# Dual-Reload Buffered PWM Timer

A 16-bit down-counting timer that produces a pulse-width-modulated waveform. The waveform has two phases. The low phase lasts for the value of the low-phase reload register plus one count tick. The high phase lasts for the value of the high-phase reload register plus one count tick. Each time the counter passes zero, the output flips, a one-cycle underflow pulse is raised, and the counter reloads with the length of the phase that begins.

Software changes the period in two steps. It writes the high-phase value first, and this write alone changes nothing. It then writes the low-phase value. That second write copies the current high-phase value into a staging buffer and marks the pair as waiting. The waiting pair moves into the working copy that the counter uses only at the end of a high phase. So a new setting always begins with a full low phase of the new pair. A pair committed in the same cycle as that end point misses it and takes effect one period later. The old waveform runs in the meantime.

The count only advances on cycles that carry a count-clock enable, so the block can be fed from any prescaler. When the run enable is low, the output is held low and no pulse is raised. Raising the enable restarts the waveform with a low phase.

Top module: `pwm_dual_reload`

## Requirements
- R1: After synchronous reset, `wave_o` and `udf_pulse_o` are 0, and the low-phase reload, high-phase reload, staging buffer and working copy are all 0 with no pair waiting.
- R2: While running, the counter moves down by one only on cycles where `cnt_en` is 1. A phase therefore spans exactly (reload + 1) enabled ticks, however the enables are spaced.
- R3: An underflow is a cycle with `cnt_en` = 1 while the counter is 0. In the cycle after it, `wave_o` has flipped and `udf_pulse_o` is 1 for exactly that cycle.
- R4: `wave_o` = 0 marks the low phase, whose length comes from the working low value. `wave_o` = 1 marks the high phase, whose length comes from the working high value.
- R5: Writing only the high-phase register (`set_hi_wr` = 1, `set_lo_wr` = 0) leaves the waveform unchanged.
- R6: Writing the low-phase register stores `set_val` as the new low value. It also captures the high-phase register content held before that cycle into the staging buffer and marks the pair waiting. Later high-phase writes do not alter the staged pair.
- R7: A waiting pair is copied to the working copy at the underflow that ends a high phase. The low phase that follows already uses the new low value.
- R8: A low-phase write made in the same cycle as the high-to-low underflow is not applied there. The old pair runs one more full period, and the new pair starts at the following boundary.
- R9: While `en` = 0, the output is 0 from the next cycle and no pulse is raised. On the first enabled cycle, any waiting pair is applied first. The counter then loads the working low value and a low phase begins.
- R10: When both write strobes are 1 in the same cycle, the staging buffer receives the old high-phase value, and both registers take `set_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable |
| cnt_en | input | 1 | Count-clock enable, one tick per cycle when high |
| set_lo_wr | input | 1 | Write strobe for the low-phase reload register (commits the pair) |
| set_hi_wr | input | 1 | Write strobe for the high-phase reload register |
| set_val | input | 16 | Write data for both reload registers |
| wave_o | output | 1 | PWM output |
| udf_pulse_o | output | 1 | One-cycle underflow interrupt pulse |

## Verification
The assertions assume that reset is held for at least two cycles, so that every `$past` term refers to values settled under reset. They also assume that the inputs are stable around the clock edge. The bench holds reset for five cycles and changes every input one time unit after a rising edge. It lands the R8 write exactly on a high-to-low underflow by consulting its own reference model, not the design. This keeps the same-cycle case inside the timing the assertions expect.

// File: rtl/pwmdr_pkg.sv
package pwmdr_pkg;
    parameter int unsigned CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t lo;
        cnt_t hi;
    } pair_t;

    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } phase_t;

    localparam pair_t PAIR_RST = '{lo: '0, hi: '0};

    function automatic phase_t flip_phase(input phase_t p);
        return (p == PH_LO) ? PH_HI : PH_LO;
    endfunction

    function automatic cnt_t phase_load(input phase_t nxt, input pair_t w);
        return (nxt == PH_HI) ? w.hi : w.lo;
    endfunction
endpackage

// File: rtl/pwmdr_regs.sv
module pwmdr_regs
    import pwmdr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_lo,
    input  logic  wr_hi,
    input  cnt_t  din,
    input  logic  take,
    output pair_t staged,
    output logic  pend
);
    cnt_t hi_q;
    pair_t stg_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            stg_q  <= PAIR_RST;
            pend_q <= 1'b0;
        end else begin
            if (wr_hi) hi_q <= din;
            if (wr_lo) begin
                stg_q.lo <= din;
                stg_q.hi <= hi_q;
                pend_q   <= 1'b1;
            end else if (take) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign staged = stg_q;
    assign pend   = pend_q;

    // R5: high-phase write alone never touches the staged pair
    p_hi_alone_r5: assert property (@(posedge clk) disable iff (rst)
        $past(wr_hi && !wr_lo) |-> (stg_q == $past(stg_q)));

    // R6 / R10: low write stages data with the previous high value
    p_stage_pair_r6: assert property (@(posedge clk) disable iff (rst)
        $past(wr_lo) |-> (pend_q && stg_q.lo == $past(din) && stg_q.hi == $past(hi_q)));
endmodule

// File: rtl/pwmdr_core.sv
module pwmdr_core
    import pwmdr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  cnt_en,
    input  pair_t staged,
    input  logic  pend,
    output logic  take,
    output logic  wave,
    output logic  irq
);
    cnt_t   cnt_q;
    phase_t ph_q;
    pair_t  work_q;
    logic   run_q;
    logic   irq_q;

    logic   start, udf, boundary;
    pair_t  work_nx;
    phase_t ph_nx;

    always_comb begin
        start    = en && !run_q;
        udf      = en && run_q && cnt_en && (cnt_q == '0);
        boundary = udf && (ph_q == PH_HI);
        take     = (start || boundary) && pend;
        work_nx  = take ? staged : work_q;
        ph_nx    = flip_phase(ph_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            ph_q   <= PH_LO;
            work_q <= PAIR_RST;
            run_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (!en) begin
                run_q <= 1'b0;
                ph_q  <= PH_LO;
            end else if (start) begin
                run_q  <= 1'b1;
                ph_q   <= PH_LO;
                work_q <= work_nx;
                cnt_q  <= work_nx.lo;
            end else if (cnt_en) begin
                if (cnt_q == '0) begin
                    ph_q   <= ph_nx;
                    irq_q  <= 1'b1;
                    work_q <= work_nx;
                    cnt_q  <= phase_load(ph_nx, work_nx);
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign wave = (ph_q == PH_HI);
    assign irq  = irq_q;

    // R2: count moves by one on enabled ticks, holds otherwise
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        $past(run_q && en && cnt_en && cnt_q != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        $past(run_q && en && !cnt_en) |-> (cnt_q == $past(cnt_q)));

    // R3: pulse comes with a flip of the output
    p_pulse_flip_r3: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (wave != $past(wave)));

    // R7: waiting pair lands in the working copy at the high-to-low underflow
    p_commit_end_r7: assert property (@(posedge clk) disable iff (rst)
        $past(boundary && pend) |-> (work_q == $past(staged) && !wave));

    // R9: disabled means low output and no pulse
    p_off_low_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> (!wave && !irq_q));
endmodule

// File: rtl/pwm_dual_reload.sv
module pwm_dual_reload
    import pwmdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             cnt_en,
    input  logic             set_lo_wr,
    input  logic             set_hi_wr,
    input  logic [CNT_W-1:0] set_val,
    output logic             wave_o,
    output logic             udf_pulse_o
);
    pair_t staged;
    logic  pend;
    logic  take;

    pwmdr_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_lo  (set_lo_wr),
        .wr_hi  (set_hi_wr),
        .din    (set_val),
        .take   (take),
        .staged (staged),
        .pend   (pend)
    );

    pwmdr_core u_core (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .cnt_en (cnt_en),
        .staged (staged),
        .pend   (pend),
        .take   (take),
        .wave   (wave_o),
        .irq    (udf_pulse_o)
    );

    // R3: a pulse never lasts beyond the flip it accompanies unless another underflow occurs
    p_pulse_needs_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        (udf_pulse_o && $past(udf_pulse_o)) |-> (wave_o != $past(wave_o)));
endmodule

// File: tb/pwm_dual_reload_tb.sv
module pwm_dual_reload_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic cnt_en = 1'b0;
    logic set_lo_wr = 1'b0;
    logic set_hi_wr = 1'b0;
    logic [15:0] set_val = '0;
    logic wave_o, udf_pulse_o;

    int n_chk = 0;
    int n_bad = 0;
    int gate_div = 1;

    always #5 clk = ~clk;

    pwm_dual_reload u_dut (
        .clk(clk), .rst(rst), .en(en), .cnt_en(cnt_en),
        .set_lo_wr(set_lo_wr), .set_hi_wr(set_hi_wr), .set_val(set_val),
        .wave_o(wave_o), .udf_pulse_o(udf_pulse_o)
    );

    // reference model state
    logic [15:0] m_lo, m_hi, m_blo, m_bhi, m_wlo, m_whi, m_cnt;
    logic m_pend, m_run, m_ph, m_irq;
    logic [1:0] exp_q[$];

    always @(posedge clk) begin
        logic bnd, st, tk;
        logic [15:0] nlo, nhi, old_hi;
        if (rst) begin
            m_lo = 0; m_hi = 0; m_blo = 0; m_bhi = 0; m_wlo = 0; m_whi = 0;
            m_cnt = 0; m_pend = 0; m_run = 0; m_ph = 0; m_irq = 0;
        end else begin
            bnd = en && m_run && cnt_en && m_cnt == 0 && m_ph;
            st  = en && !m_run;
            tk  = (st || bnd) && m_pend;
            nlo = tk ? m_blo : m_wlo;
            nhi = tk ? m_bhi : m_whi;
            m_irq = 0;
            if (!en) begin
                m_run = 0; m_ph = 0;
            end else if (st) begin
                m_run = 1; m_ph = 0; m_wlo = nlo; m_whi = nhi; m_cnt = nlo;
            end else if (cnt_en) begin
                if (m_cnt == 0) begin
                    m_irq = 1;
                    m_wlo = nlo; m_whi = nhi;
                    m_cnt = m_ph ? nlo : nhi;
                    m_ph = !m_ph;
                end else m_cnt = m_cnt - 1;
            end
            old_hi = m_hi;
            if (set_hi_wr) m_hi = set_val;
            if (set_lo_wr) begin
                m_blo = set_val; m_bhi = old_hi; m_lo = set_val; m_pend = 1;
            end else if (tk) m_pend = 0;
        end
        exp_q.push_back({m_ph, m_irq});
    end

    // monitor: compare at the falling edge
    always @(negedge clk) begin
        logic [1:0] e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_chk++;
            if (wave_o !== e[1]) begin
                n_bad++;
                $display("FAIL R4 wave_o actual=%b expected=%b t=%0t", wave_o, e[1], $time);
            end
            n_chk++;
            if (udf_pulse_o !== e[0]) begin
                n_bad++;
                $display("FAIL R3 udf_pulse_o actual=%b expected=%b t=%0t", udf_pulse_o, e[0], $time);
            end
        end
    end

    // count-clock enable generator (R2 uses sparse ticks)
    initial begin
        int k = 0;
        forever begin
            @(posedge clk); #1;
            k++;
            cnt_en = (k % gate_div) == 0;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic lo, input logic hi, input logic [15:0] v);
        @(posedge clk); #1;
        set_lo_wr = lo; set_hi_wr = hi; set_val = v;
        @(posedge clk); #1;
        set_lo_wr = 0; set_hi_wr = 0;
    endtask

    // sync=1: wait for a falling edge; sync=0: caller is at first low negedge
    task automatic measure(input bit sync, output int lo, output int hi);
        logic prev;
        if (sync) begin
            prev = wave_o;
            forever begin
                @(negedge clk);
                if (prev && !wave_o) break;
                prev = wave_o;
            end
        end
        lo = 1;
        forever begin @(negedge clk); if (!wave_o) lo++; else break; end
        hi = 1;
        forever begin @(negedge clk); if (wave_o) hi++; else break; end
    endtask

    initial begin
        int lo, hi;
        repeat (5) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R1 wave after reset", wave_o, 0);
        check("R1 pulse after reset", udf_pulse_o, 0);

        // R9: pair waiting before enable is applied at start
        wr(0, 1, 16'd3);
        wr(1, 0, 16'd5);
        @(posedge clk); #1 en = 1;
        measure(1, lo, hi);
        check("R9 low len", lo, 6);
        check("R4 high len", hi, 4);

        // R5: high-only write
        wr(0, 1, 16'd10);
        measure(1, lo, hi);
        check("R5 low len", lo, 6);
        check("R5 high len", hi, 4);

        // R6 / R7: commit then a later high write
        wr(1, 0, 16'd2);
        wr(0, 1, 16'd20);
        measure(1, lo, hi);
        check("R7 low len", lo, 3);
        check("R6 high len", hi, 11);

        // R8: commit in the boundary cycle
        wr(0, 1, 16'd7);
        forever begin
            @(posedge clk); #1;
            if (m_cnt == 0 && m_ph && cnt_en) break;
        end
        set_lo_wr = 1; set_val = 16'd4;
        @(posedge clk); #1 set_lo_wr = 0;
        @(negedge clk);
        measure(0, lo, hi);
        check("R8 old low len", lo, 3);
        check("R8 old high len", hi, 11);
        measure(0, lo, hi);
        check("R8 new low len", lo, 5);
        check("R8 new high len", hi, 8);

        // R10: both strobes together
        wr(1, 1, 16'd1);
        measure(1, lo, hi);
        check("R10 low len", lo, 2);
        check("R10 high len", hi, 8);
        wr(1, 0, 16'd1);
        measure(1, lo, hi);
        check("R10 recommit high len", hi, 2);

        // R2: one tick every third cycle
        gate_div = 3;
        measure(1, lo, hi);
        measure(1, lo, hi);
        check("R2 low cycles", lo, 6);
        check("R2 high cycles", hi, 6);
        gate_div = 1;

        // R9: disable holds output low
        @(posedge clk); #1 en = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            check("R9 disabled wave", wave_o, 0);
            check("R9 disabled pulse", udf_pulse_o, 0);
            @(negedge clk);
        end
        wr(0, 1, 16'd2);
        wr(1, 0, 16'd3);
        @(posedge clk); #1 en = 1;
        measure(1, lo, hi);
        check("R9 restart low len", lo, 4);
        check("R9 restart high len", hi, 3);

        repeat (10) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule